// File: doc/BRIEF.md
# Streaming Polynomial Number-Theoretic Transform Engine

This block transforms one polynomial of 256 twelve-bit coefficients, each already reduced modulo the prime q = 3329. A producer streams the coefficients in, one per cycle, over a valid/ready handshake. The engine holds them in an internal buffer and runs seven butterfly layers with one butterfly per cycle. It then streams the 256 results out in index order with a valid strobe, and marks the end of the job with a single-cycle done pulse.

A mode bit picks the direction. The forward direction uses Cooley-Tukey butterflies with half-distances 128 down to 2 and does not scale the result. The inverse direction uses Gentleman-Sande butterflies with half-distances 2 up to 128, and it multiplies every result by 3303, which is the inverse of 128 modulo q. The transform is the incomplete kind that leaves 128 residues of degree one. Its twiddles are powers of the 256th root of unity 17, taken in bit-reversed order. The caller keeps its polynomial storage outside the engine. It can start a new load in the same cycle that the engine reports idle again.

Top module: `ntt_engine`

## Requirements
- R1: While reset is held, and right after it is released, ready_o is 1, valid_o is 0 and done_o is 0. A reset in the middle of a load drops the partial polynomial, and the next full transform is still correct.
- R2: In the load phase, each rising edge with valid_i and ready_o both high stores coeff_in at the next index, counting from 0. A cycle with valid_i low stores nothing. ready_o is low in the cycle after the edge that accepts index 255.
- R3: The direction is taken from mode_i at the edge that accepts index 0. The value of mode_i during the rest of the load has no effect on the result.
- R4: With mode 0, output k equals coefficient k of the forward transform. Entry i of the twiddle table is 17^bitrev7(i) mod 3329, and entry i is used from i = 1 upward, one entry per butterfly group.
- R5: With mode 1, output k equals the Gentleman-Sande inverse, with twiddle entries used from 127 downward, multiplied by 3303 mod 3329. Running forward and then inverse, or inverse and then forward, returns the original polynomial.
- R6: Exactly 256 results leave the engine, in index order 0 to 255. Each result is marked by valid_o and is in the range [0, 3329).
- R7: valid_o first goes high 896 clock cycles after the edge that accepts the last input coefficient. That is 7 layers of 128 butterflies, one per cycle.
- R8: While valid_o is high and ready_i is low, valid_o and coeff_out keep their values.
- R9: done_o is high for exactly the one cycle after the edge that transfers output 255, and ready_o is low in that cycle. In the next cycle ready_o is high, and a new load may begin there.
- R10: While ready_o is low, valid_i, coeff_in and mode_i have no effect on the results being computed or delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| coeff_in | input | 12 | Input coefficient, in [0, q) |
| valid_i | input | 1 | coeff_in is presented |
| ready_o | output | 1 | Engine is in the load phase and accepts input |
| mode_i | input | 1 | 0 selects forward without scaling, 1 selects inverse with scaling by 3303 |
| coeff_out | output | 12 | Result coefficient |
| valid_o | output | 1 | coeff_out is valid |
| ready_i | input | 1 | Downstream accepts coeff_out |
| done_o | output | 1 | One-cycle pulse after the last result |

## Verification
The engine is driven with an all-zero polynomial, unit impulses at index 0 and index 255, an all-(q-1) polynomial, a ramp and pseudo-random polynomials. Each of these is compared in full against a reference transform written separately in the bench. The impulses isolate single twiddle rows and column indexing. The all-(q-1) input stresses the top of the modular reduction range. The random inputs catch butterfly and twiddle-order faults that structured inputs miss. Round trips (forward then inverse, and inverse then forward) confirm the scaling constant. Other runs are mixed in: gaps in the input stream, a mode bit that changes after the first coefficient, input toggling while the engine is busy, and output stalls. These separate handshake faults from arithmetic faults.

// File: rtl/ntt_pkg.sv
package ntt_pkg;
  parameter int COEF_W = 12;
  parameter int LOGN   = 8;
  parameter int N      = 1 << LOGN;
  parameter int HALF   = N / 2;
  parameter int LAYERS = LOGN - 1;
  parameter int IDX_W  = LOGN;
  parameter int LYR_W  = $clog2(LAYERS);
  parameter int BFLY_TOTAL = LAYERS * HALF;
  parameter int BCNT_W = $clog2(BFLY_TOTAL + 1);

  parameter int Q      = 3329;
  parameter int ZETA   = 17;
  parameter int NINV   = 3303;
  parameter int RED_K  = 2 * COEF_W;
  parameter int RED_M  = (1 << RED_K) / Q;

  parameter logic [COEF_W:0]   Q_W    = (COEF_W+1)'(Q);
  parameter logic [COEF_W-1:0] NINV_W = COEF_W'(NINV);

  typedef logic [COEF_W-1:0] coef_t;

  typedef enum logic [1:0] {
    PH_LOAD = 2'd0,
    PH_COMP = 2'd1,
    PH_OUT  = 2'd2,
    PH_DONE = 2'd3
  } phase_e;

  // Barrett reduction of a product of two residues.
  function automatic coef_t mod_reduce(input logic [2*COEF_W-1:0] x);
    logic [3*COEF_W+1:0] prod;
    logic [COEF_W+1:0]   quot;
    logic [2*COEF_W:0]   rem;
    prod = (3*COEF_W+2)'(x) * (3*COEF_W+2)'(RED_M);
    quot = prod[RED_K +: COEF_W+2];
    rem  = (2*COEF_W+1)'(x) - (2*COEF_W+1)'(quot) * (2*COEF_W+1)'(Q);
    if (rem >= (2*COEF_W+1)'(Q)) rem = rem - (2*COEF_W+1)'(Q);
    return rem[COEF_W-1:0];
  endfunction

  function automatic coef_t mod_mul(input coef_t a, input coef_t b);
    return mod_reduce((2*COEF_W)'(a) * (2*COEF_W)'(b));
  endfunction

  function automatic coef_t mod_add(input coef_t a, input coef_t b);
    logic [COEF_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= Q_W) s = s - Q_W;
    return s[COEF_W-1:0];
  endfunction

  function automatic coef_t mod_sub(input coef_t a, input coef_t b);
    logic [COEF_W:0] d;
    if (a >= b) d = {1'b0, a} - {1'b0, b};
    else        d = {1'b0, a} + Q_W - {1'b0, b};
    return d[COEF_W-1:0];
  endfunction

  // Elaboration-time helpers for the twiddle table.
  function automatic int bit_rev(input int v, input int bits);
    int r;
    r = 0;
    for (int i = 0; i < bits; i++) r = (r << 1) | ((v >> i) & 1);
    return r;
  endfunction

  function automatic int zeta_pow(input int e);
    int r;
    r = 1;
    for (int i = 0; i < e; i++) r = (r * ZETA) % Q;
    return r;
  endfunction
endpackage

// File: rtl/ntt_twiddle_rom.sv
module ntt_twiddle_rom
  import ntt_pkg::*;
(
  input  logic [LAYERS-1:0] idx,
  output logic [COEF_W-1:0] zeta
);
  logic [COEF_W-1:0] tab [HALF];

  for (genvar k = 0; k < HALF; k++) begin : g_tw
    localparam int          EXPO = bit_rev(k, LAYERS);
    localparam logic [COEF_W-1:0] VAL = COEF_W'(zeta_pow(EXPO));
    assign tab[k] = VAL;
  end

  assign zeta = tab[idx];
endmodule

// File: rtl/ntt_butterfly.sv
module ntt_butterfly
  import ntt_pkg::*;
(
  input  logic              inv,
  input  logic [COEF_W-1:0] a_i,
  input  logic [COEF_W-1:0] b_i,
  input  logic [COEF_W-1:0] zeta_i,
  output logic [COEF_W-1:0] a_o,
  output logic [COEF_W-1:0] b_o
);
  logic [COEF_W-1:0] tw_prod;   // zeta * b     (Cooley-Tukey)
  logic [COEF_W-1:0] diff_ba;   // b - a        (Gentleman-Sande)
  logic [COEF_W-1:0] gs_prod;

  assign tw_prod = mod_mul(zeta_i, b_i);
  assign diff_ba = mod_sub(b_i, a_i);
  assign gs_prod = mod_mul(zeta_i, diff_ba);

  always_comb begin
    if (inv) begin
      a_o = mod_add(a_i, b_i);
      b_o = gs_prod;
    end else begin
      a_o = mod_add(a_i, tw_prod);
      b_o = mod_sub(a_i, tw_prod);
    end
  end
endmodule

// File: rtl/ntt_bfly_sched.sv
module ntt_bfly_sched
  import ntt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic              inv,
  output logic [IDX_W-1:0]  j0,
  output logic [IDX_W-1:0]  j1,
  output logic [LAYERS-1:0] tw_idx,
  output logic              at_last
);
  logic [LYR_W-1:0]  layer_q;
  logic [LAYERS-1:0] bidx_q;
  logic [3:0]        span_log;
  logic [IDX_W-1:0]  span, grp, off, base, k_fwd, k_inv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      layer_q <= '0;
      bidx_q  <= '0;
    end else if (step_en) begin
      if (bidx_q == LAYERS'(HALF - 1)) begin
        bidx_q  <= '0;
        layer_q <= at_last ? '0 : layer_q + 1'b1;
      end else begin
        bidx_q <= bidx_q + 1'b1;
      end
    end
  end

  always_comb begin
    if (inv) span_log = 4'(layer_q) + 4'd1;
    else     span_log = 4'(LAYERS) - 4'(layer_q);
    span  = IDX_W'(1) << span_log;
    grp   = IDX_W'(bidx_q) >> span_log;
    off   = IDX_W'(bidx_q) & (span - 1'b1);
    base  = grp << (span_log + 4'd1);
    k_fwd = (IDX_W'(1) << layer_q) + grp;
    k_inv = (IDX_W'(HALF) >> layer_q) - IDX_W'(1) - grp;
  end

  assign j0      = base | off;
  assign j1      = (base | off) + span;
  assign tw_idx  = inv ? k_inv[LAYERS-1:0] : k_fwd[LAYERS-1:0];
  assign at_last = (layer_q == LYR_W'(LAYERS - 1)) && (bidx_q == LAYERS'(HALF - 1));
endmodule

// File: rtl/ntt_engine.sv
module ntt_engine
  import ntt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [COEF_W-1:0] coeff_in,
  input  logic              valid_i,
  output logic              ready_o,
  input  logic              mode_i,
  output logic [COEF_W-1:0] coeff_out,
  output logic              valid_o,
  input  logic              ready_i,
  output logic              done_o
);
  phase_e             phase_q;
  logic [IDX_W-1:0]   cnt_q;
  logic               inv_q;
  logic [COEF_W-1:0]  mem [N];

  // Named internal events.
  logic load_fire, load_last, bfly_fire, bfly_last, out_fire, out_last;

  logic [IDX_W-1:0]   j0, j1;
  logic [LAYERS-1:0]  tw_idx;
  logic               sched_last;
  logic [COEF_W-1:0]  zeta, a_new, b_new, out_raw, out_scaled;

  assign ready_o   = (phase_q == PH_LOAD);
  assign valid_o   = (phase_q == PH_OUT);
  assign done_o    = (phase_q == PH_DONE);

  assign load_fire = ready_o && valid_i;
  assign load_last = load_fire && (cnt_q == IDX_W'(N - 1));
  assign bfly_fire = (phase_q == PH_COMP);
  assign bfly_last = bfly_fire && sched_last;
  assign out_fire  = valid_o && ready_i;
  assign out_last  = out_fire && (cnt_q == IDX_W'(N - 1));

  ntt_bfly_sched u_sched (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_en (bfly_fire),
    .inv     (inv_q),
    .j0      (j0),
    .j1      (j1),
    .tw_idx  (tw_idx),
    .at_last (sched_last)
  );

  ntt_twiddle_rom u_rom (
    .idx  (tw_idx),
    .zeta (zeta)
  );

  ntt_butterfly u_bfly (
    .inv    (inv_q),
    .a_i    (mem[j0]),
    .b_i    (mem[j1]),
    .zeta_i (zeta),
    .a_o    (a_new),
    .b_o    (b_new)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_LOAD;
      cnt_q   <= '0;
      inv_q   <= 1'b0;
    end else begin
      case (phase_q)
        PH_LOAD: if (load_fire) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == '0) inv_q <= mode_i;
          if (load_last)   phase_q <= PH_COMP;
        end
        PH_COMP: if (bfly_last) phase_q <= PH_OUT;
        PH_OUT: if (out_fire) begin
          cnt_q <= cnt_q + 1'b1;
          if (out_last) phase_q <= PH_DONE;
        end
        default: phase_q <= PH_LOAD;
      endcase
    end
  end

  // Coefficient buffer: load writes one word, a butterfly writes a pair.
  always_ff @(posedge clk) begin
    if (load_fire) begin
      mem[cnt_q] <= coeff_in;
    end else if (bfly_fire) begin
      mem[j0] <= a_new;
      mem[j1] <= b_new;
    end
  end

  assign out_raw    = mem[cnt_q];
  assign out_scaled = mod_mul(out_raw, NINV_W);
  assign coeff_out  = inv_q ? out_scaled : out_raw;
endmodule

// File: rtl/ntt_engine_chk.sv
module ntt_engine_chk
  import ntt_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ready_o,
  input logic              valid_o,
  input logic              done_o,
  input logic              ready_i,
  input logic [COEF_W-1:0] coeff_out,
  input logic              load_fire,
  input logic              bfly_fire,
  input logic              out_fire
);
  logic [IDX_W:0]    lcnt, ocnt;
  logic [BCNT_W-1:0] bcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lcnt <= '0;
      ocnt <= '0;
      bcnt <= '0;
    end else begin
      if (done_o)         lcnt <= '0;
      else if (load_fire) lcnt <= lcnt + 1'b1;
      if (done_o)         ocnt <= '0;
      else if (out_fire)  ocnt <= ocnt + 1'b1;
      if (load_fire)      bcnt <= '0;
      else if (bfly_fire) bcnt <= bcnt + 1'b1;
    end
  end

  a_r2_load_count: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready_o) |-> lcnt == (IDX_W+1)'(N));

  a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_o) |-> bcnt == BCNT_W'(BFLY_TOTAL));

  a_r6_out_count: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ocnt == (IDX_W+1)'(N));

  a_r6_out_range: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> coeff_out < COEF_W'(Q));

  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(coeff_out)));

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && ready_o));

  a_r9_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !ready_o);

  a_r10_ready_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> $past(done_o));

  a_r10_phase_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ready_o, valid_o, done_o}));
endmodule

bind ntt_engine ntt_engine_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ready_o   (ready_o),
  .valid_o   (valid_o),
  .done_o    (done_o),
  .ready_i   (ready_i),
  .coeff_out (coeff_out),
  .load_fire (load_fire),
  .bfly_fire (bfly_fire),
  .out_fire  (out_fire)
);

// File: tb/sim_ntt_engine.sv
`timescale 1ns/1ps
module sim_ntt_engine;
  localparam int QM = 3329;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] coeff_in = '0;
  logic        valid_i = 1'b0;
  logic        mode_i = 1'b0;
  logic        ready_i = 1'b1;
  logic        ready_o, valid_o, done_o;
  logic [11:0] coeff_out;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  ntt_engine u0 (
    .clk(clk), .rst_n(rst_n), .coeff_in(coeff_in), .valid_i(valid_i),
    .ready_o(ready_o), .mode_i(mode_i), .coeff_out(coeff_out),
    .valid_o(valid_o), .ready_i(ready_i), .done_o(done_o)
  );

  typedef int poly_t[256];
  // kind: 0 zero, 1 impulse at arg, 2 all q-1, 3 ramp i*arg, 4 random seed arg, 5 previous result
  typedef struct packed {
    logic        mode;
    logic        flip;
    logic [2:0]  kind;
    logic        gap;
    logic        stall;
    logic        noise;
    logic [15:0] arg;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 16'd0},
    '{1'b0, 1'b1, 3'd1, 1'b0, 1'b0, 1'b0, 16'd0},
    '{1'b0, 1'b0, 3'd1, 1'b1, 1'b0, 1'b0, 16'd255},
    '{1'b0, 1'b0, 3'd2, 1'b0, 1'b1, 1'b0, 16'd0},
    '{1'b0, 1'b0, 3'd4, 1'b0, 1'b0, 1'b1, 16'hACE1},
    '{1'b1, 1'b0, 3'd5, 1'b1, 1'b1, 1'b0, 16'd0},
    '{1'b1, 1'b1, 3'd4, 1'b0, 1'b0, 1'b1, 16'h1234},
    '{1'b0, 1'b0, 3'd5, 1'b0, 1'b1, 1'b0, 16'd0},
    '{1'b1, 1'b0, 3'd2, 1'b0, 1'b0, 1'b0, 16'd0},
    '{1'b0, 1'b0, 3'd3, 1'b1, 1'b0, 1'b0, 16'd7}
  };

  int    zt [128];
  poly_t last_in, last_out;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic build_zetas();
    int pw [128];
    pw[0] = 1;
    for (int e = 1; e < 128; e++) pw[e] = (pw[e-1] * 17) % QM;
    for (int k = 0; k < 128; k++) begin
      int r = 0;
      for (int b = 0; b < 7; b++) if (k & (1 << b)) r += 1 << (6 - b);
      zt[k] = pw[r];
    end
  endtask

  task automatic ref_xform(input poly_t a, input bit inv, output poly_t f);
    int k;
    f = a;
    if (!inv) begin
      k = 1;
      for (int len = 128; len >= 2; len = len / 2)
        for (int st = 0; st < 256; st += 2 * len) begin
          int z = zt[k];
          k++;
          for (int j = st; j < st + len; j++) begin
            int t = (z * f[j+len]) % QM;
            f[j+len] = (f[j] - t + QM) % QM;
            f[j]     = (f[j] + t) % QM;
          end
        end
    end else begin
      k = 127;
      for (int len = 2; len <= 128; len = len * 2)
        for (int st = 0; st < 256; st += 2 * len) begin
          int z = zt[k];
          k--;
          for (int j = st; j < st + len; j++) begin
            int t = f[j];
            f[j]     = (t + f[j+len]) % QM;
            f[j+len] = (z * ((f[j+len] - t + QM) % QM)) % QM;
          end
        end
      for (int j = 0; j < 256; j++) f[j] = (f[j] * 3303) % QM;
    end
  endtask

  task automatic make_poly(input vec_t v, output poly_t p);
    int x = int'(v.arg);
    for (int i = 0; i < 256; i++) begin
      case (v.kind)
        3'd1:    p[i] = (i == int'(v.arg)) ? 1 : 0;
        3'd2:    p[i] = QM - 1;
        3'd3:    p[i] = (i * int'(v.arg)) % QM;
        3'd4: begin
          x = x * 1103515245 + 12345;
          p[i] = ((x >>> 16) & 32767) % QM;
        end
        3'd5:    p[i] = last_out[i];
        default: p[i] = 0;
      endcase
    end
  endtask

  // Called at a negedge with ready_o high; returns at a negedge with ready_o high.
  task automatic run_vec(input vec_t v, input int vi);
    poly_t in, exp, got;
    int    cyc, n, c, mism, first_bad;
    bit    stalled, held, inrange, rdy;
    logic [11:0] prev;
    string req;
    make_poly(v, in);
    ref_xform(in, v.mode, exp);

    for (int i = 0; i < 256; i++) begin
      if (v.gap && (i % 4 == 2)) begin
        valid_i  = 1'b0;
        coeff_in = 12'hFFF;
        @(posedge clk); @(negedge clk);
      end
      valid_i  = 1'b1;
      coeff_in = 12'(in[i]);
      mode_i   = (i == 0 || !v.flip) ? v.mode : ~v.mode;
      @(posedge clk); @(negedge clk);
    end
    check(ready_o == 1'b0, "R2", $sformatf("v%0d ready_o after index 255", vi), int'(ready_o), 0);

    if (v.noise) begin
      valid_i = 1'b1; coeff_in = 12'h5A5; mode_i = ~v.mode;
    end else begin
      valid_i = 1'b0;
    end

    cyc = 0;
    while (!valid_o && cyc < 2000) begin
      @(posedge clk); @(negedge clk);
      cyc++;
    end
    check(cyc == 896, "R7", $sformatf("v%0d cycles to first valid_o", vi), cyc, 896);

    n = 0; c = 0; stalled = 0; held = 1; inrange = 1; prev = '0;
    while (n < 256 && c < 2000) begin
      rdy = v.stall ? (c % 3 != 1) : 1'b1;
      ready_i = rdy;
      if (!valid_o) held = 0;
      if (stalled && coeff_out !== prev) held = 0;
      if (int'(coeff_out) >= QM) inrange = 0;
      if (v.noise) coeff_in = 12'(c * 37);
      if (rdy) begin
        got[n] = int'(coeff_out);
        n++;
      end
      stalled = !rdy;
      prev = coeff_out;
      c++;
      @(posedge clk); @(negedge clk);
    end
    check(n == 256, "R6", $sformatf("v%0d results collected", vi), n, 256);

    mism = 0; first_bad = -1;
    for (int i = 0; i < 256; i++)
      if (got[i] != exp[i]) begin
        mism++;
        if (first_bad < 0) first_bad = i;
      end
    if (v.noise)     req = "R10";
    else if (v.flip) req = "R3";
    else if (v.mode) req = "R5";
    else             req = "R4";
    if (first_bad < 0) first_bad = 0;
    check(mism == 0, req, $sformatf("v%0d result[%0d] (%0d mismatches)", vi, first_bad, mism),
          got[first_bad], exp[first_bad]);
    if (v.stall) check(held, "R8", $sformatf("v%0d output held under stall", vi), int'(held), 1);
    check(inrange, "R6", $sformatf("v%0d outputs below q", vi), int'(inrange), 1);

    if (v.kind == 3'd5) begin
      mism = 0; first_bad = 0;
      for (int i = 0; i < 256; i++)
        if (got[i] != last_in[i]) begin
          if (mism == 0) first_bad = i;
          mism++;
        end
      check(mism == 0, "R5", $sformatf("v%0d round trip [%0d]", vi, first_bad),
            got[first_bad], last_in[first_bad]);
    end

    check(done_o == 1'b1 && ready_o == 1'b0, "R9", $sformatf("v%0d done with ready low", vi),
          int'({done_o, ready_o}), 2);
    valid_i = 1'b0;
    ready_i = 1'b1;
    @(posedge clk); @(negedge clk);
    check(ready_o == 1'b1 && done_o == 1'b0, "R9", $sformatf("v%0d idle after done", vi),
          int'({done_o, ready_o}), 1);

    last_in  = in;
    last_out = got;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    n_tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    build_zetas();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(ready_o && !valid_o && !done_o, "R1", "outputs during reset",
          int'({ready_o, valid_o, done_o}), 4);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check(ready_o && !valid_o && !done_o, "R1", "outputs after reset",
          int'({ready_o, valid_o, done_o}), 4);

    for (int v = 0; v < 10; v++) run_vec(VECS[v], v);

    // R1: reset in the middle of a load discards the partial polynomial.
    for (int i = 0; i < 100; i++) begin
      valid_i = 1'b1; coeff_in = 12'(i * 13); mode_i = 1'b1;
      @(posedge clk); @(negedge clk);
    end
    valid_i = 1'b0;
    rst_n = 1'b0;
    @(posedge clk); @(negedge clk);
    check(ready_o && !valid_o && !done_o, "R1", "idle after mid-load reset",
          int'({ready_o, valid_o, done_o}), 4);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    run_vec(VECS[4], 10);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule